// File: doc/BRIEF.md
# Page Access Permission and Reference/Change Update Unit

This unit handles the final step of an address translation, after the walk has already reached a leaf page-table entry. It receives the leaf entry, the address that entry was read from, and the access context: access type, problem (user) state, translation scope, and an authority-mask permission triple. From these it decides whether the access may proceed.

On a fault it returns a cause vector and grants nothing. On success it returns the granted permission set and sets the entry's referenced and changed bits. If the entry changed, it stores the entry back through a memory write port. The result is reported only after that write has been accepted.

One request is handled at a time. A request is taken when `req_valid` is high while `req_ready` is high. The result appears as a one-cycle pulse on `rsp_valid`.

Top module: `pte_access_gate`

## Requirements
- R1: The access type is encoded as 00 read, 01 write, 10 execute, with 11 treated as read. When entry bits 5:4 hold 2'b10 (non-idempotent I/O) and the access is execute, the result is a fault with cause 3'b001 (guarded no-execute, bit 0) and nothing else.
- R2: For a process-scoped access (`req_part`=0) in problem state (`req_prob`=1) to a privileged page (entry bit 3 set), the granted permission set is empty.
- R3: For a process-scoped, supervisor (`req_prob`=0) access to a non-privileged page, the granted set is the entry's permissions in bits 2:0 (bit 0 read, bit 1 write, bit 2 execute) ANDed with `req_amr` (same bit order).
- R4: In every other scope and state combination (partition-scoped access, or supervisor access to a privileged page, or problem-state access to a non-privileged page), the granted set is entry bits 2:0 unchanged.
- R5: If the bit needed by the access type is missing from the granted set, the result is a fault with cause bit 1 (protection) set. Needed bits: read needs bit 0, write needs bit 1, execute needs bit 2. On any fault, `rsp_perm` is 0 and no write is issued.
- R6: A protection fault on a write access also sets cause bit 2 (store indicator). On any other fault, cause bit 2 is clear.
- R7: On an allowed access, the updated entry has bit 8 (referenced) set. It also has bit 7 (changed) set when the access is a write. All other bits are unchanged.
- R8: On an allowed non-write access, `rsp_perm` is the granted set with bit 1 (write) cleared. On an allowed write, `rsp_perm` is the full granted set.
- R9: Exactly one write of the updated entry, to `req_addr`, is issued when the update changes at least one bit. When the update changes nothing, no write is issued.
- R10: `wr_valid`, `wr_addr` and `wr_data` are held stable until `wr_ready` is seen. `rsp_valid` rises only after the write is accepted and lasts exactly one cycle.
- R11: After reset the unit is idle: `req_ready`=1, `wr_valid`=0, `rsp_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Unit idle, request will be taken |
| req_pte | input | PTE_W | Leaf page-table entry |
| req_addr | input | ADDR_W | Address the entry was read from |
| req_acc | input | 2 | Access type (00 read, 01 write, 10 execute, 11 read) |
| req_prob | input | 1 | Problem (user) state |
| req_part | input | 1 | 1 = partition-scoped, 0 = process-scoped |
| req_amr | input | 3 | Authority-mask permissions (read, write, execute) |
| wr_valid | output | 1 | Entry write-back request |
| wr_ready | input | 1 | Write-back accepted |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | PTE_W | Updated entry |
| rsp_valid | output | 1 | One-cycle result strobe |
| rsp_fault | output | 1 | Access denied |
| rsp_cause | output | 3 | Fault cause (bit 0 guard, bit 1 protection, bit 2 store) |
| rsp_perm | output | 3 | Granted permissions |

## Verification
The stimulus sweeps every combination of entry permission bits, privileged bit, attribute code, and prior referenced/changed state. Each is crossed with every access type, both problem-state values and both scopes, while the authority mask rotates through all eight values.

The attribute sweep separates the guarded-execute fault from an ordinary protection fault. The privilege, scope and mask crossings separate the three permission rules from one another.

The prior referenced/changed state separates accesses that need a write-back from those that do not. The write acceptance is delayed by zero, one or two cycles, which shows that the write-back is held stable and the response waits for it.

// File: rtl/pag_pkg.sv
package pag_pkg;
  typedef enum logic [1:0] {
    ACC_RD  = 2'b00,
    ACC_WR  = 2'b01,
    ACC_EX  = 2'b10,
    ACC_RD2 = 2'b11
  } acc_e;

  localparam int PERM_LSB = 0;
  localparam int PRIV_BIT = 3;
  localparam int ATT_LSB  = 4;
  localparam int CHG_BIT  = 7;
  localparam int REF_BIT  = 8;
  localparam logic [1:0] ATT_NIO = 2'b10;

  localparam int CZ_GUARD = 0;
  localparam int CZ_PROT  = 1;
  localparam int CZ_STORE = 2;

  // permission bit needed by an access type
  function automatic logic [2:0] need_of(input logic [1:0] acc);
    case (acc)
      ACC_WR:  need_of = 3'b010;
      ACC_EX:  need_of = 3'b100;
      default: need_of = 3'b001;
    endcase
  endfunction

  // granted set from page permissions, privilege, state and scope
  function automatic logic [2:0] grant_of(input logic [2:0] eaa, input logic priv,
                                          input logic prob, input logic part,
                                          input logic [2:0] amr);
    if (!part && priv && prob)       grant_of = 3'b000;
    else if (!part && !priv && !prob) grant_of = eaa & amr;
    else                              grant_of = eaa;
  endfunction
endpackage

// File: rtl/pag_perm.sv
module pag_perm
  import pag_pkg::*;
(
  input  logic [5:0] pte_lo,
  input  logic [1:0] acc,
  input  logic       prob,
  input  logic       part,
  input  logic [2:0] amr,
  output logic       guard_hit,
  output logic       prot_hit,
  output logic       fault,
  output logic [2:0] cause,
  output logic [2:0] perm
);
  logic [2:0] granted;
  logic       is_wr;

  always_comb begin
    is_wr     = (acc == ACC_WR);
    granted   = grant_of(pte_lo[PERM_LSB +: 3], pte_lo[PRIV_BIT], prob, part, amr);
    guard_hit = (pte_lo[ATT_LSB +: 2] == ATT_NIO) && (acc == ACC_EX);
    prot_hit  = !guard_hit && ((need_of(acc) & granted) == 3'b000);
    fault     = guard_hit || prot_hit;
    cause     = 3'b000;
    cause[CZ_GUARD] = guard_hit;
    cause[CZ_PROT]  = prot_hit;
    cause[CZ_STORE] = prot_hit && is_wr;
    if (fault)      perm = 3'b000;
    else if (is_wr) perm = granted;
    else            perm = granted & 3'b101;
  end
endmodule

// File: rtl/pag_rc.sv
module pag_rc
  import pag_pkg::*;
#(
  parameter int PTE_W = 64
) (
  input  logic [PTE_W-1:0] pte,
  input  logic [1:0]       acc,
  output logic [PTE_W-1:0] new_pte,
  output logic             dirty
);
  always_comb begin
    new_pte          = pte;
    new_pte[REF_BIT] = 1'b1;
    if (acc == ACC_WR) new_pte[CHG_BIT] = 1'b1;
    dirty = (new_pte != pte);
  end
endmodule

// File: rtl/pag_ctrl.sv
module pag_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic req_valid,
  input  logic fault,
  input  logic dirty,
  input  logic wr_ready,
  output logic req_ready,
  output logic capture,
  output logic latch,
  output logic wr_valid,
  output logic rsp_valid
);
  typedef enum logic [1:0] {S_IDLE, S_EVAL, S_WRITE, S_RESP} st_e;
  st_e st, st_n;

  always_comb begin
    st_n = st;
    case (st)
      S_IDLE:  if (req_valid) st_n = S_EVAL;
      S_EVAL:  st_n = (fault || !dirty) ? S_RESP : S_WRITE;
      S_WRITE: if (wr_ready) st_n = S_RESP;
      default: st_n = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) st <= S_IDLE;
    else        st <= st_n;

  assign req_ready = (st == S_IDLE);
  assign capture   = req_ready && req_valid;
  assign latch     = (st == S_EVAL);
  assign wr_valid  = (st == S_WRITE);
  assign rsp_valid = (st == S_RESP);
endmodule

// File: rtl/pte_access_gate.sv
module pte_access_gate
  import pag_pkg::*;
#(
  parameter int PTE_W  = 64,
  parameter int ADDR_W = 56
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [PTE_W-1:0]  req_pte,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [1:0]        req_acc,
  input  logic              req_prob,
  input  logic              req_part,
  input  logic [2:0]        req_amr,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [PTE_W-1:0]  wr_data,
  output logic              rsp_valid,
  output logic              rsp_fault,
  output logic [2:0]        rsp_cause,
  output logic [2:0]        rsp_perm
);
  logic [PTE_W-1:0]  pte_q, new_q, new_pte;
  logic [ADDR_W-1:0] addr_q;
  logic [1:0]        acc_q;
  logic              prob_q, part_q;
  logic [2:0]        amr_q;
  logic              capture, latch;
  logic              guard_hit, prot_hit, fault, dirty;
  logic [2:0]        cause, perm;
  logic              res_fault;
  logic [2:0]        res_cause, res_perm;

  pag_perm u_perm (
    .pte_lo(pte_q[5:0]), .acc(acc_q), .prob(prob_q), .part(part_q), .amr(amr_q),
    .guard_hit(guard_hit), .prot_hit(prot_hit), .fault(fault),
    .cause(cause), .perm(perm)
  );

  pag_rc #(.PTE_W(PTE_W)) u_rc (
    .pte(pte_q), .acc(acc_q), .new_pte(new_pte), .dirty(dirty)
  );

  pag_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .fault(fault),
    .dirty(dirty), .wr_ready(wr_ready), .req_ready(req_ready),
    .capture(capture), .latch(latch), .wr_valid(wr_valid), .rsp_valid(rsp_valid)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pte_q  <= '0;
      addr_q <= '0;
      acc_q  <= ACC_RD;
      prob_q <= 1'b0;
      part_q <= 1'b0;
      amr_q  <= '0;
    end else if (capture) begin
      pte_q  <= req_pte;
      addr_q <= req_addr;
      acc_q  <= req_acc;
      prob_q <= req_prob;
      part_q <= req_part;
      amr_q  <= req_amr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_fault <= 1'b0;
      res_cause <= '0;
      res_perm  <= '0;
      new_q     <= '0;
    end else if (latch) begin
      res_fault <= fault;
      res_cause <= cause;
      res_perm  <= perm;
      new_q     <= new_pte;
    end
  end

  assign wr_addr   = addr_q;
  assign wr_data   = new_q;
  assign rsp_fault = res_fault;
  assign rsp_cause = res_cause;
  assign rsp_perm  = res_perm;
endmodule

// File: rtl/pag_checker.sv
module pag_checker #(
  parameter int PTE_W = 64
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_ready,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [PTE_W-1:0] wr_data,
  input logic [PTE_W-1:0] pte_q,
  input logic [1:0]       acc_q,
  input logic             rsp_valid,
  input logic             rsp_fault,
  input logic [2:0]       rsp_cause,
  input logic [2:0]       rsp_perm
);
  p_guard_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && acc_q == 2'b10 && pte_q[5:4] == 2'b10 |-> rsp_fault && rsp_cause == 3'b001);

  p_fault_noperm_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_fault |-> rsp_perm == 3'b000);

  p_store_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && acc_q != 2'b01 |-> !rsp_cause[2]);

  p_ref_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data[8]);

  p_chg_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && acc_q == 2'b01 |-> wr_data[7]);

  p_nowrite_perm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && acc_q != 2'b01 |-> !rsp_perm[1]);

  p_real_change_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> wr_data != pte_q);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && !wr_ready |=> wr_valid && $stable(wr_data));

  p_rsp_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_exclusive_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({req_ready, wr_valid, rsp_valid}));
endmodule

bind pte_access_gate pag_checker #(.PTE_W(PTE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .wr_valid(wr_valid),
  .wr_ready(wr_ready), .wr_data(wr_data), .pte_q(pte_q), .acc_q(acc_q),
  .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
  .rsp_perm(rsp_perm)
);

// File: tb/sim_pte_access_gate.sv
module sim_pte_access_gate;
  localparam int PTE_W  = 64;
  localparam int ADDR_W = 56;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [PTE_W-1:0]  req_pte = '0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [1:0]        req_acc = '0;
  logic              req_prob = 1'b0;
  logic              req_part = 1'b0;
  logic [2:0]        req_amr = '0;
  logic              wr_valid;
  logic              wr_ready = 1'b0;
  logic [ADDR_W-1:0] wr_addr;
  logic [PTE_W-1:0]  wr_data;
  logic              rsp_valid, rsp_fault;
  logic [2:0]        rsp_cause, rsp_perm;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pte_access_gate #(.PTE_W(PTE_W), .ADDR_W(ADDR_W)) u0 (.*);

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_case(input int i);
    logic [63:0] pte, exp_pte, got_wdata;
    logic [ADDR_W-1:0] got_waddr, addr;
    logic [1:0] acc;
    logic prob, part, priv, is_wr, nio, fault;
    logic [2:0] amr, eaa, grant, need, exp_cause, exp_perm;
    int delay, waitc, nwr;
    bit got, seen;
    logic [63:0] prev;
    pte = 64'hA5C3_0F00_0000_0000 ^ (64'(i) << 24);
    pte[5:0] = i[5:0];
    pte[6] = 1'b0;
    pte[7] = i[6];
    pte[8] = i[7];
    acc  = i[9:8];
    prob = i[10];
    part = i[11];
    amr  = 3'((i * 3 + (i >> 4)) & 7);
    addr = ADDR_W'(64'h0012_3456_0000 + 64'(i) * 8);
    delay = i % 3;
    // expected result (R1..R9)
    eaa  = pte[2:0];
    priv = pte[3];
    is_wr = (acc == 2'b01);
    need = (acc == 2'b01) ? 3'b010 : (acc == 2'b10) ? 3'b100 : 3'b001;
    if (!part && prob && priv)       grant = 3'b000;
    else if (!part && !prob && !priv) grant = eaa & amr;
    else                              grant = eaa;
    nio = (pte[5:4] == 2'b10) && (acc == 2'b10);
    fault = nio || ((grant & need) == 3'b000);
    if (nio) exp_cause = 3'b001;
    else if (fault) exp_cause = is_wr ? 3'b110 : 3'b010;
    else exp_cause = 3'b000;
    exp_perm = fault ? 3'b000 : (is_wr ? grant : (grant & 3'b101));
    exp_pte = pte;
    if (!fault) begin
      exp_pte[8] = 1'b1;
      if (is_wr) exp_pte[7] = 1'b1;
    end
    // drive request
    @(negedge clk);
    chk(req_ready == 1'b1, "R11 ready when idle", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_pte = pte; req_addr = addr;
    req_acc = acc; req_prob = prob; req_part = part; req_amr = amr;
    @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0; seen = 1'b0; waitc = 0; nwr = 0;
    got_wdata = '0; got_waddr = '0; prev = '0;
    for (int c = 0; c < 30 && !got; c++) begin
      if (wr_ready) wr_ready = 1'b0;
      if (rsp_valid) begin
        got = 1'b1;
        chk(!wr_valid, "R10 response with write pending", 64'(wr_valid), 64'd0);
      end else begin
        if (wr_valid) begin
          if (seen) chk(wr_data == prev, "R10 write data held", wr_data, prev);
          seen = 1'b1; prev = wr_data;
          if (waitc == delay) begin
            wr_ready = 1'b1;
            nwr++;
            got_wdata = wr_data;
            got_waddr = wr_addr;
          end else waitc++;
        end
        @(negedge clk);
      end
    end
    chk(got, "R10 response seen", 64'(got), 64'd1);
    chk(rsp_fault == fault, nio ? "R1 fault" : "R5 fault", 64'(rsp_fault), 64'(fault));
    chk(rsp_cause == exp_cause, nio ? "R1 cause" : "R6 cause", 64'(rsp_cause), 64'(exp_cause));
    chk(rsp_perm == exp_perm,
        (!part && prob && priv) ? "R2 perm" :
        (!part && !prob && !priv) ? "R3 perm" : "R4 perm / R8",
        64'(rsp_perm), 64'(exp_perm));
    chk(nwr == ((exp_pte != pte) ? 1 : 0), "R9 write count", 64'(nwr),
        64'((exp_pte != pte) ? 1 : 0));
    if (nwr == 1) begin
      chk(got_wdata == exp_pte, "R7 written entry", got_wdata, exp_pte);
      chk(got_waddr == addr, "R9 write address", 64'(got_waddr), 64'(addr));
    end
    @(negedge clk);
    chk(!rsp_valid, "R10 one-cycle response", 64'(rsp_valid), 64'd0);
  endtask

  initial begin
    #4_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R11 reset ready", 64'(req_ready), 64'd1);
    chk(wr_valid == 1'b0, "R11 reset write idle", 64'(wr_valid), 64'd0);
    chk(rsp_valid == 1'b0, "R11 reset response idle", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < 4096; i++) run_case(i);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule